// File: doc/BRIEF.md
# TDM Multichannel Slot Selector

This block sits beside the serial shifters of a time-division-multiplexed port. It decides, slot by slot, whether the receiver captures the current channel, and whether the transmitter loads data for it and drives the line. A frame carries up to 128 channels, counted in groups of sixteen called blocks. The block runs one channel counter per direction. The counter clears on that direction's frame-sync strobe and steps forward on each element-done strobe. The current block of each direction is reported as the channel number divided by sixteen.

Channel eligibility comes from a flat 128-bit enable vector per direction. This vector is four 32-bit words concatenated, with word 0 in bits 31:0, so bit n belongs to channel n. In eight-partition mode every channel reads its own bit. In two-partition mode only two blocks are selectable. The block chosen for partition A reads bits 15:0 and the block chosen for partition B reads bits 31:16. Every other block is disabled.

The receiver either takes every channel or only the selected ones. The transmitter has four policies, chosen by a 2-bit field. Control values are plain input ports that the surrounding port logic holds steady.

Top module: `tdm_slot_selector`

## Requirements
- R1: After reset both channel counters are 0, so both current-block outputs read 0. With all control inputs at 0, receive-enable and transmit-enable are 1 and transmit-mask is 0.
- R2: In each direction, a frame-sync strobe makes the channel 0 after the next clock edge. An element-done strobe without frame-sync adds one, wrapping from 127 to 0. With neither strobe the channel holds. Frame-sync wins when both are high. The current-block output is the channel divided by 16 (channel bits 6:4).
- R3: With receive select-only at 0, receive-enable is 1 for every channel, whatever the receive enable bits and partition settings hold.
- R4: In two-partition mode (partition bit 0), a channel in the block named by the partition A field takes enable bit (channel mod 16). A channel in the block named by the partition B field takes enable bit 16 + (channel mod 16).
- R5: In two-partition mode, a channel whose block matches neither partition field is not selected. When both fields name the same block, partition A wins.
- R6: In eight-partition mode (partition bit 1), channel n takes enable bit n, and the block fields have no effect.
- R7: Transmit mode 0 gives transmit-enable 1 and transmit-mask 0 for every channel, and the transmit partition bit has no effect.
- R8: Transmit mode 1 sets transmit-enable to the channel's selection from the transmit settings, and transmit-mask to its inverse.
- R9: Transmit mode 2 holds transmit-enable at 1 and sets transmit-mask to the inverse of the channel's selection from the transmit settings.
- R10: Transmit mode 3 selects from the receive partition A/B fields and the receive enable vector, using the transmit partition bit. Transmit-enable is the selection and transmit-mask is its inverse.
- R11: The receive and transmit channel counters advance and clear independently, each only on its own direction's strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxFrameSync | input | 1 | Receive frame start strobe, clears the receive channel |
| rxElemDone | input | 1 | Receive element boundary strobe, advances the receive channel |
| txFrameSync | input | 1 | Transmit frame start strobe |
| txElemDone | input | 1 | Transmit element boundary strobe |
| rxSelectOnly | input | 1 | 0: all channels received, 1: only selected channels |
| rxEightPart | input | 1 | Receive partition mode, 0 two-partition, 1 eight-partition |
| rxBlkA | input | 3 | Receive block assigned to partition A |
| rxBlkB | input | 3 | Receive block assigned to partition B |
| rxEnable | input | 128 | Receive enable words 0..3, bit n for channel n |
| txMode | input | 2 | Transmit policy: 0 all, 1 enable-only, 2 mask, 3 symmetric |
| txEightPart | input | 1 | Transmit partition mode |
| txBlkA | input | 3 | Transmit block assigned to partition A |
| txBlkB | input | 3 | Transmit block assigned to partition B |
| txEnable | input | 128 | Transmit enable words 0..3, bit n for channel n |
| rxSlotEn | output | 1 | Receiver takes the current slot |
| txSlotEn | output | 1 | Transmitter loads data for the current slot |
| txSlotMask | output | 1 | Transmit line is released (high impedance) in the current slot |
| rxCurBlk | output | 3 | Block of the current receive channel |
| txCurBlk | output | 3 | Block of the current transmit channel |

## Verification
The bench drives the counter through the 127-to-0 wrap and through frame-sync colliding with element-done. A design that drops the priority or saturates would leave the block output at a wrong value for the rest of the frame. It sets both partition fields to the same block, which exposes a design that lets B override A or reads a wrong half of word 0. It also puts enable ones into unassigned blocks, which exposes a design that leaks them into the slot. Symmetric transmit is run with transmit enables and block fields deliberately different from the receive ones. A design that kept reading the transmit settings would then send in the wrong slots. Random runs vary all modes together against a bench model.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  typedef enum logic [1:0] {
    TX_ALL     = 2'd0,
    TX_ENONLY  = 2'd1,
    TX_MASKED  = 2'd2,
    TX_SYMM    = 2'd3
  } txPolicy_t;

  typedef struct packed {
    logic clr;
    logic adv;
  } stepStrobe_t;

  typedef struct packed {
    logic rxUseSel;
    logic txUseSel;
    logic txUseRxMap;
    logic txDriveAll;
  } slotPolicy_t;

endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int CH_W = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tdm_slot_pkg::stepStrobe_t  step,
  output logic [CH_W-1:0]            chan
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chan <= '0;
    end else if (step.clr) begin
      chan <= '0;
    end else if (step.adv) begin
      chan <= chan + CH_W'(1);
    end
  end

endmodule

// File: rtl/tdm_slot_ctrl.sv
module tdm_slot_ctrl
  import tdm_slot_pkg::*;
(
  input  logic        rxFrameSync,
  input  logic        rxElemDone,
  input  logic        txFrameSync,
  input  logic        txElemDone,
  input  logic        rxSelectOnly,
  input  logic [1:0]  txMode,
  output stepStrobe_t rxStep,
  output stepStrobe_t txStep,
  output slotPolicy_t policy
);

  txPolicy_t txPol;

  always_comb begin
    txPol = txPolicy_t'(txMode);

    // frame start has priority over an element boundary
    rxStep.clr = rxFrameSync;
    rxStep.adv = rxElemDone & ~rxFrameSync;
    txStep.clr = txFrameSync;
    txStep.adv = txElemDone & ~txFrameSync;

    policy.rxUseSel   = rxSelectOnly;
    policy.txUseSel   = (txPol != TX_ALL);
    policy.txUseRxMap = (txPol == TX_SYMM);
    policy.txDriveAll = (txPol == TX_ALL) || (txPol == TX_MASKED);
  end

endmodule

// File: rtl/tdm_slot_datapath.sv
module tdm_slot_datapath
  import tdm_slot_pkg::*;
#(
  parameter int NUM_CH   = 128,
  parameter int BLK_SIZE = 16,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int OFF_W   = $clog2(BLK_SIZE),
  localparam int BLK_W   = CH_W - OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  stepStrobe_t        rxStep,
  input  stepStrobe_t        txStep,
  input  slotPolicy_t        policy,
  input  logic               rxEightPart,
  input  logic [BLK_W-1:0]   rxBlkA,
  input  logic [BLK_W-1:0]   rxBlkB,
  input  logic [NUM_CH-1:0]  rxEnable,
  input  logic               txEightPart,
  input  logic [BLK_W-1:0]   txBlkA,
  input  logic [BLK_W-1:0]   txBlkB,
  input  logic [NUM_CH-1:0]  txEnable,
  output logic [CH_W-1:0]    rxChan,
  output logic [CH_W-1:0]    txChan,
  output logic               rxSlotEn,
  output logic               txSlotEn,
  output logic               txSlotMask,
  output logic [BLK_W-1:0]   rxCurBlk,
  output logic [BLK_W-1:0]   txCurBlk
);

  localparam int NUM_DIR = 2;

  stepStrobe_t            stepArr [NUM_DIR];
  logic [CH_W-1:0]        chanArr [NUM_DIR];

  assign stepArr[0] = rxStep;
  assign stepArr[1] = txStep;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    tdm_slot_counter #(.CH_W(CH_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .step (stepArr[d]),
      .chan (chanArr[d])
    );
  end

  assign rxChan   = chanArr[0];
  assign txChan   = chanArr[1];
  assign rxCurBlk = rxChan[CH_W-1:OFF_W];
  assign txCurBlk = txChan[CH_W-1:OFF_W];

  // Selection of one channel under either partition mode
  function automatic logic pickBit(
    input logic [CH_W-1:0]   ch,
    input logic              eight,
    input logic [BLK_W-1:0]  blkA,
    input logic [BLK_W-1:0]  blkB,
    input logic [NUM_CH-1:0] words
  );
    logic [BLK_W-1:0] blk;
    logic [CH_W-1:0]  idxA;
    logic [CH_W-1:0]  idxB;
    blk  = ch[CH_W-1:OFF_W];
    idxA = CH_W'(ch[OFF_W-1:0]);
    idxB = CH_W'(BLK_SIZE) + CH_W'(ch[OFF_W-1:0]);
    if (eight)             return words[ch];
    else if (blk == blkA)  return words[idxA];
    else if (blk == blkB)  return words[idxB];
    else                   return 1'b0;
  endfunction

  logic rxSel;
  logic txSelOwn;
  logic txSelSym;
  logic txSel;

  always_comb begin
    rxSel    = pickBit(rxChan, rxEightPart, rxBlkA, rxBlkB, rxEnable);
    txSelOwn = pickBit(txChan, txEightPart, txBlkA, txBlkB, txEnable);
    txSelSym = pickBit(txChan, txEightPart, rxBlkA, rxBlkB, rxEnable);
    txSel    = policy.txUseRxMap ? txSelSym : txSelOwn;

    rxSlotEn   = ~policy.rxUseSel | rxSel;
    txSlotEn   = ~policy.txUseSel | policy.txDriveAll | txSel;
    txSlotMask = policy.txUseSel & ~txSel;
  end

endmodule

// File: rtl/tdm_slot_selector.sv
module tdm_slot_selector
  import tdm_slot_pkg::*;
#(
  parameter int NUM_CH   = 128,
  parameter int BLK_SIZE = 16,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int BLK_W   = CH_W - $clog2(BLK_SIZE)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxFrameSync,
  input  logic               rxElemDone,
  input  logic               txFrameSync,
  input  logic               txElemDone,
  input  logic               rxSelectOnly,
  input  logic               rxEightPart,
  input  logic [BLK_W-1:0]   rxBlkA,
  input  logic [BLK_W-1:0]   rxBlkB,
  input  logic [NUM_CH-1:0]  rxEnable,
  input  logic [1:0]         txMode,
  input  logic               txEightPart,
  input  logic [BLK_W-1:0]   txBlkA,
  input  logic [BLK_W-1:0]   txBlkB,
  input  logic [NUM_CH-1:0]  txEnable,
  output logic               rxSlotEn,
  output logic               txSlotEn,
  output logic               txSlotMask,
  output logic [BLK_W-1:0]   rxCurBlk,
  output logic [BLK_W-1:0]   txCurBlk
);

  stepStrobe_t     rxStep;
  stepStrobe_t     txStep;
  slotPolicy_t     policy;
  logic [CH_W-1:0] rxChan;
  logic [CH_W-1:0] txChan;

  tdm_slot_ctrl u_ctrl (
    .rxFrameSync  (rxFrameSync),
    .rxElemDone   (rxElemDone),
    .txFrameSync  (txFrameSync),
    .txElemDone   (txElemDone),
    .rxSelectOnly (rxSelectOnly),
    .txMode       (txMode),
    .rxStep       (rxStep),
    .txStep       (txStep),
    .policy       (policy)
  );

  tdm_slot_datapath #(.NUM_CH(NUM_CH), .BLK_SIZE(BLK_SIZE)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .rxStep      (rxStep),
    .txStep      (txStep),
    .policy      (policy),
    .rxEightPart (rxEightPart),
    .rxBlkA      (rxBlkA),
    .rxBlkB      (rxBlkB),
    .rxEnable    (rxEnable),
    .txEightPart (txEightPart),
    .txBlkA      (txBlkA),
    .txBlkB      (txBlkB),
    .txEnable    (txEnable),
    .rxChan      (rxChan),
    .txChan      (txChan),
    .rxSlotEn    (rxSlotEn),
    .txSlotEn    (txSlotEn),
    .txSlotMask  (txSlotMask),
    .rxCurBlk    (rxCurBlk),
    .txCurBlk    (txCurBlk)
  );

endmodule

// File: rtl/tdm_slot_selector_checker.sv
module tdm_slot_selector_checker #(
  parameter int CH_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            rxFrameSync,
  input logic            rxElemDone,
  input logic            txFrameSync,
  input logic            txElemDone,
  input logic            rxSelectOnly,
  input logic [1:0]      txMode,
  input logic [CH_W-1:0] rxChan,
  input logic [CH_W-1:0] txChan,
  input logic            rxSlotEn,
  input logic            txSlotEn,
  input logic            txSlotMask
);

  a_r2_rx_sync_clears: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameSync |=> (rxChan == '0));

  a_r2_rx_step: assert property (@(posedge clk) disable iff (!rstN)
    (rxElemDone && !rxFrameSync) |=> (rxChan == $past(rxChan) + CH_W'(1)));

  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!rxElemDone && !rxFrameSync) |=> $stable(rxChan));

  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!txElemDone && !txFrameSync) |=> $stable(txChan));

  a_r2_tx_sync_clears: assert property (@(posedge clk) disable iff (!rstN)
    txFrameSync |=> (txChan == '0));

  a_r3_rx_all: assert property (@(posedge clk) disable iff (!rstN)
    !rxSelectOnly |-> rxSlotEn);

  a_r7_tx_all: assert property (@(posedge clk) disable iff (!rstN)
    (txMode == 2'd0) |-> (txSlotEn && !txSlotMask));

  a_r9_tx_drive: assert property (@(posedge clk) disable iff (!rstN)
    (txMode == 2'd2) |-> txSlotEn);

  a_r8_mask_inverse: assert property (@(posedge clk) disable iff (!rstN)
    ((txMode == 2'd1) || (txMode == 2'd3)) |-> (txSlotMask == !txSlotEn));

endmodule

bind tdm_slot_selector tdm_slot_selector_checker #(.CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rxFrameSync  (rxFrameSync),
  .rxElemDone   (rxElemDone),
  .txFrameSync  (txFrameSync),
  .txElemDone   (txElemDone),
  .rxSelectOnly (rxSelectOnly),
  .txMode       (txMode),
  .rxChan       (rxChan),
  .txChan       (txChan),
  .rxSlotEn     (rxSlotEn),
  .txSlotEn     (txSlotEn),
  .txSlotMask   (txSlotMask)
);

// File: tb/tdm_slot_selector_bench.sv
`timescale 1ns/1ps
module tdm_slot_selector_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic         rxFrameSync = 0, rxElemDone = 0, txFrameSync = 0, txElemDone = 0;
  logic         rxSelectOnly = 0, rxEightPart = 0, txEightPart = 0;
  logic [2:0]   rxBlkA = 0, rxBlkB = 0, txBlkA = 0, txBlkB = 0;
  logic [127:0] rxEnable = '0, txEnable = '0;
  logic [1:0]   txMode = 0;
  logic         rxSlotEn, txSlotEn, txSlotMask;
  logic [2:0]   rxCurBlk, txCurBlk;

  tdm_slot_selector u_tdm_slot_selector (
    .clk(clk), .rstN(rstN),
    .rxFrameSync(rxFrameSync), .rxElemDone(rxElemDone),
    .txFrameSync(txFrameSync), .txElemDone(txElemDone),
    .rxSelectOnly(rxSelectOnly), .rxEightPart(rxEightPart),
    .rxBlkA(rxBlkA), .rxBlkB(rxBlkB), .rxEnable(rxEnable),
    .txMode(txMode), .txEightPart(txEightPart),
    .txBlkA(txBlkA), .txBlkB(txBlkB), .txEnable(txEnable),
    .rxSlotEn(rxSlotEn), .txSlotEn(txSlotEn), .txSlotMask(txSlotMask),
    .rxCurBlk(rxCurBlk), .txCurBlk(txCurBlk)
  );

  int  nTests = 0;
  int  nFail  = 0;
  bit  finished = 0;
  int  mRx = 0;
  int  mTx = 0;

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (rxCh %0d txCh %0d)", req, act, exp, mRx, mTx);
    end
  endtask

  function automatic bit selOf(input int ch, input bit eight, input int a, input int b,
                               input logic [127:0] w);
    int blk;
    blk = ch / 16;
    if (eight) return w[ch];
    if (blk == a) return w[ch % 16];
    if (blk == b) return w[16 + ch % 16];
    return 1'b0;
  endfunction

  // Compare every output with the model at the current channel and controls
  task automatic checkAll();
    bit rs, ts, eEn, eMask, eRx;
    string tTag;
    #1;
    rs  = selOf(mRx, rxEightPart, rxBlkA, rxBlkB, rxEnable);
    eRx = rxSelectOnly ? rs : 1'b1;
    if (txMode == 2'd3) ts = selOf(mTx, txEightPart, rxBlkA, rxBlkB, rxEnable);
    else                ts = selOf(mTx, txEightPart, txBlkA, txBlkB, txEnable);
    case (txMode)
      2'd0: begin eEn = 1; eMask = 0;   tTag = "R7";  end
      2'd1: begin eEn = ts; eMask = !ts; tTag = "R8";  end
      2'd2: begin eEn = 1; eMask = !ts; tTag = "R9";  end
      default: begin eEn = ts; eMask = !ts; tTag = "R10"; end
    endcase
    chk(!rxSelectOnly ? "R3 rxEn" : (rxEightPart ? "R6 rxEn" : "R4 rxEn"), rxSlotEn, eRx);
    chk({tTag, " txEn"}, txSlotEn, eEn);
    chk({tTag, " txMask"}, txSlotMask, eMask);
    chk("R2 rxCurBlk", rxCurBlk, mRx / 16);
    chk("R11 txCurBlk", txCurBlk, mTx / 16);
  endtask

  // Drive strobes on a negedge, let one edge pass, update model
  task automatic step(input bit rfs, input bit red, input bit tfs, input bit ted);
    @(negedge clk);
    rxFrameSync = rfs; rxElemDone = red; txFrameSync = tfs; txElemDone = ted;
    @(posedge clk);
    if (rfs) mRx = 0; else if (red) mRx = (mRx + 1) % 128;
    if (tfs) mTx = 0; else if (ted) mTx = (mTx + 1) % 128;
    @(negedge clk);
    rxFrameSync = 0; rxElemDone = 0; txFrameSync = 0; txElemDone = 0;
    checkAll();
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    #1;
    chk("R1 rxCurBlk", rxCurBlk, 0);
    chk("R1 txCurBlk", txCurBlk, 0);
    chk("R1 rxEn", rxSlotEn, 1);
    chk("R1 txEn", txSlotEn, 1);
    chk("R1 txMask", txSlotMask, 0);

    // R2: wrap from 127 to 0
    for (int i = 0; i < 127; i++) step(0, 1, 0, 0);
    chk("R2 rx at 127", rxCurBlk, 7);
    chk("R11 tx idle", txCurBlk, 0);
    step(0, 1, 0, 1);
    chk("R2 wrap", rxCurBlk, 0);
    // R2: frame-sync wins over element-done
    for (int i = 0; i < 20; i++) step(0, 1, 0, 1);
    step(1, 1, 0, 0);
    chk("R2 sync priority", rxCurBlk, 0);
    chk("R11 tx kept", txCurBlk, 1);

    // R5: A and B name the same block, A wins; unassigned blocks dark
    rxSelectOnly = 1; rxEightPart = 0; rxBlkA = 3'd2; rxBlkB = 3'd2;
    rxEnable = '1;
    rxEnable[31:16] = '0;
    rxEnable[3] = 1'b0;
    step(1, 0, 1, 0);
    for (int i = 0; i < 64; i++) begin
      step(0, 1, 0, 0);
      chk("R5 rx sel", rxSlotEn, (mRx / 16 == 2) && (mRx % 16 != 3));
    end

    // R10: symmetric transmit reads receive settings, not transmit ones
    txMode = 2'd3; txEightPart = 0; txBlkA = 3'd0; txBlkB = 3'd1; txEnable = '1;
    rxBlkA = 3'd1; rxBlkB = 3'd3; rxEnable = '0;
    rxEnable[5] = 1'b1; rxEnable[16 + 9] = 1'b1;
    step(1, 0, 1, 0);
    for (int i = 0; i < 64; i++) begin
      step(0, 0, 0, 1);
      chk("R10 symm", txSlotEn, (mTx == 21) || (mTx == 57));
    end

    // R7: partition bit has no effect in mode 0
    txMode = 2'd0; txEightPart = 1; txEnable = '0;
    step(0, 0, 0, 1);
    chk("R7 txEn", txSlotEn, 1);
    chk("R7 txMask", txSlotMask, 0);

    // Random mix of modes, enables and strobes
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 16 == 0) begin
        rxSelectOnly = 1'($urandom);
        rxEightPart  = 1'($urandom);
        txEightPart  = 1'($urandom);
        txMode       = 2'($urandom);
        rxBlkA = 3'($urandom); rxBlkB = 3'($urandom);
        txBlkA = 3'($urandom); txBlkB = 3'($urandom);
        rxEnable = {$urandom, $urandom, $urandom, $urandom};
        txEnable = {$urandom, $urandom, $urandom, $urandom};
      end
      step($urandom % 64 == 0, $urandom % 4 != 0, $urandom % 64 == 0, $urandom % 3 != 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule